// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block decides when the clocks of a small 8-bit microcontroller may run. Software writes a 4-bit power-control register. One bit asks for a light sleep in which only the CPU clock stops. Another bit asks for a deep sleep in which the oscillator is switched off. Two further bits are spare flag storage. The block turns these requests into a CPU clock enable, a peripheral clock enable and an oscillator enable. It also raises hold levels that freeze the port outputs and keep the external bus strobes high while the core is stopped.

Light sleep ends when the interrupt controller reports an enabled interrupt as pending. Deep sleep ends only on a wake pin that is enabled. When one of the two active-low external interrupt pins goes low, the oscillator restarts. The oscillator must then report ready and run for a programmable number of stable cycles. After that, the release of a pin that went low completes the exit. A keyboard wake follows a different path: once the oscillator is ready, the block waits a fixed number of cycles and then resumes without waiting for any release. An asynchronous reset ends either sleep state at once.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released, cpu_clk_en, per_clk_en and osc_en are 1, strobe_hold and port_hold are 0, and ctrl_rd is 0. Pulling rst_n low ends either sleep state immediately.
- R2: Writing ctrl_wdata with bit 0 set (idle request) and bit 1 clear stops the CPU clock from the second rising edge after the write. per_clk_en and osc_en stay 1, and strobe_hold and port_hold become 1.
- R3: In idle, a high irq_pend at a rising edge clears bit 0 of ctrl_rd and sets cpu_clk_en back to 1 from that edge on.
- R4: Bits 3:2 of the register are general flags. They read back on ctrl_rd exactly as written, and no sleep entry or exit changes them.
- R5: Writing bit 1 (power-down request) drives osc_en, cpu_clk_en and per_clk_en to 0 and strobe_hold and port_hold to 1. irq_pend has no effect on this state.
- R6: When bits 0 and 1 are written together, power-down is entered and ctrl_rd shows bit 0 as 0.
- R7: An external pin whose bit in ext_en is 0 cannot wake the block. osc_en stays 0 while that pin is low.
- R8: An enabled ext_n pin that is low after its two-stage synchronizer sets osc_en to 1. The CPU clock stays off for as long as that pin is held low. Its release, seen through the synchronizer, returns cpu_clk_en to 1 on the third rising edge after the release and clears bit 1 of ctrl_rd.
- R9: After a wake, cpu_clk_en cannot return until osc_ready has been high on stab_limit rising edges. If the pin was released early, the exit takes place on the edge right after the last counted cycle.
- R10: When both pins are enabled, either pin going low restarts the oscillator. The first release of a pin that went low completes the exit, even if the other pin is still low.
- R11: An enabled keyboard wake (kbd_irq high, kbd_en 1) restarts the oscillator. After osc_ready has been high on KBD_DLY rising edges (1024 by default), the block resumes and needs no release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Register write strobe |
| ctrl_wdata | input | 4 | Write data: bit0 idle, bit1 power-down, bits3:2 flags |
| ctrl_rd | output | 4 | Register read value |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_n | input | NUM_EXT | Active-low external interrupt pins |
| ext_en | input | NUM_EXT | Per-pin wake enables |
| kbd_irq | input | 1 | Keyboard interrupt request, active high |
| kbd_en | input | 1 | Keyboard wake enable |
| osc_ready | input | 1 | Oscillator reports it is running |
| stab_limit | input | STAB_W | Stable-cycle count for pin wakes |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Forces the bus strobes high |
| port_hold | output | 1 | Freezes the port output latches |

## Verification
Idle is tried both with the flag bits clear and with them set, which shows that the wake clears only the request bit. Power-down is left through a pin that was released early, once with a count of 10 and once with a count of 3. In that case the exit time follows the count alone. It is also left through a pin held low well past the count, where the exit time follows the release. With both pins enabled, pin 1 is released while pin 0 stays low, which separates "first release" from "all released". A disabled pin held low, irq_pend in power-down, the combined write and the 1024-cycle keyboard path each tell a qualified wake apart from a stray one.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CTRL_W   = 4;
  localparam int BIT_IDLE = 0;
  localparam int BIT_PD   = 1;
  localparam int BIT_GF0  = 2;
  localparam int BIT_GF1  = 3;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_PD_OFF = 3'd2,
    ST_PD_OSC = 3'd3,
    ST_PD_REL = 3'd4
  } pmc_state_e;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_KBD = 1'b1
  } wake_src_e;
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              clr_idle,
  input  logic              clr_pd,
  output logic              idle_req,
  output logic              pd_req,
  output logic [CTRL_W-1:0] rdata
);
  logic       idle_q, idle_d;
  logic       pd_q, pd_d;
  logic [1:0] gf_q, gf_d;

  always_comb begin
    idle_d = idle_q;
    pd_d   = pd_q;
    gf_d   = gf_q;
    if (we) begin
      // power-down wins when both requests arrive together
      idle_d = wdata[BIT_IDLE] & ~wdata[BIT_PD];
      pd_d   = wdata[BIT_PD];
      gf_d   = {wdata[BIT_GF1], wdata[BIT_GF0]};
    end
    if (clr_idle) idle_d = 1'b0;
    if (clr_pd)   pd_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b0;
      pd_q   <= 1'b0;
      gf_q   <= 2'b00;
    end else begin
      idle_q <= idle_d;
      pd_q   <= pd_d;
      gf_q   <= gf_d;
    end
  end

  assign idle_req = idle_q;
  assign pd_req   = pd_q;
  assign rdata    = {gf_q, pd_q, idle_q};

  assert_pd_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[BIT_IDLE] && wdata[BIT_PD] && !clr_pd) |=> (pd_q && !idle_q));

  assert_flags_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> $stable(gf_q));
endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int NUM_EXT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic               kbd_irq,
  input  logic               kbd_en,
  input  logic               arm_clr,
  input  logic               arm_act,
  output logic               ext_low_hit,
  output logic               ext_release,
  output logic               kbd_hit
);
  logic [NUM_EXT-1:0] pin_low;
  logic [NUM_EXT-1:0] armed_q, armed_d;
  logic [SYNC_STAGES-1:0] kbd_sync_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXT; gi++) begin : g_pin
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_n[gi]};
      end
      assign pin_low[gi] = ~sync_q[SYNC_STAGES-1];

      assert_arm_low_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_act && !arm_clr && ext_en[gi] && pin_low[gi]) |=> armed_q[gi]);
      assert_no_arm_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_clr) |=> !armed_q[gi]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kbd_sync_q <= '0;
    else        kbd_sync_q <= {kbd_sync_q[SYNC_STAGES-2:0], kbd_irq};
  end

  always_comb begin
    armed_d = armed_q;
    if (arm_clr)      armed_d = '0;
    else if (arm_act) armed_d = armed_q | (ext_en & pin_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= '0;
    else        armed_q <= armed_d;
  end

  assign ext_low_hit = |(ext_en & pin_low);
  assign ext_release = |(armed_q & ~pin_low);
  assign kbd_hit     = kbd_en & kbd_sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/pmc_seq_fsm.sv
module pmc_seq_fsm
  import pmc_pkg::*;
#(
  parameter int STAB_W  = 8,
  parameter int KBD_DLY = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              pd_req,
  input  logic              irq_pend,
  input  logic              ext_low_hit,
  input  logic              ext_release,
  input  logic              kbd_hit,
  input  logic              osc_ready,
  input  logic [STAB_W-1:0] stab_limit,
  output logic              clr_idle,
  output logic              clr_pd,
  output logic              arm_clr,
  output logic              arm_act,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              strobe_hold,
  output logic              port_hold
);
  localparam int KBD_W = $clog2(KBD_DLY + 1);
  localparam int CNT_W = (KBD_W > STAB_W) ? KBD_W : STAB_W;

  pmc_state_e       st_q, st_d;
  wake_src_e        src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] target;
  logic             cnt_done;

  assign target   = (src_q == SRC_KBD) ? CNT_W'(KBD_DLY) : CNT_W'(stab_limit);
  assign cnt_done = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, target};

  always_comb begin
    st_d     = st_q;
    src_d    = src_q;
    cnt_d    = cnt_q;
    clr_idle = 1'b0;
    clr_pd   = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        cnt_d = '0;
        if (pd_req)        st_d = ST_PD_OFF;
        else if (idle_req) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (irq_pend) begin
          st_d     = ST_RUN;
          clr_idle = 1'b1;
        end
      end
      ST_PD_OFF: begin
        cnt_d = '0;
        if (ext_low_hit) begin
          st_d  = ST_PD_OSC;
          src_d = SRC_EXT;
        end else if (kbd_hit) begin
          st_d  = ST_PD_OSC;
          src_d = SRC_KBD;
        end
      end
      ST_PD_OSC: begin
        if (osc_ready) begin
          if (cnt_done) begin
            if (src_q == SRC_KBD) begin
              st_d   = ST_RUN;
              clr_pd = 1'b1;
            end else begin
              st_d = ST_PD_REL;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_PD_REL: begin
        if (ext_release) begin
          st_d   = ST_RUN;
          clr_pd = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      src_q <= SRC_EXT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      src_q <= src_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    cpu_clk_en  = (st_q == ST_RUN);
    per_clk_en  = (st_q == ST_RUN) || (st_q == ST_IDLE);
    osc_en      = (st_q != ST_PD_OFF);
    strobe_hold = (st_q != ST_RUN);
    port_hold   = (st_q != ST_RUN);
    arm_clr     = (st_q == ST_RUN) || (st_q == ST_IDLE);
    arm_act     = (st_q == ST_PD_OFF) || (st_q == ST_PD_OSC) || (st_q == ST_PD_REL);
  end

  assert_idle_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && irq_pend) |=> cpu_clk_en);

  assert_pd_no_stray_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PD_OFF && !ext_low_hit && !kbd_hit) |=> !osc_en);

  assert_osc_start_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(ext_low_hit || kbd_hit));

  assert_cpu_after_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en) && $past(st_q) == ST_PD_OSC) |-> $past(osc_ready));

  assert_rel_waits_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PD_REL && !ext_release) |=> !cpu_clk_en);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int STAB_W      = 8,
  parameter int KBD_DLY     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [3:0]         ctrl_wdata,
  output logic [3:0]         ctrl_rd,
  input  logic               irq_pend,
  input  logic [NUM_EXT-1:0] ext_n,
  input  logic [NUM_EXT-1:0] ext_en,
  input  logic               kbd_irq,
  input  logic               kbd_en,
  input  logic               osc_ready,
  input  logic [STAB_W-1:0]  stab_limit,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en,
  output logic               strobe_hold,
  output logic               port_hold
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       idle_req, pd_req, clr_idle, clr_pd;
  logic       arm_clr, arm_act;
  logic       ext_low_hit, ext_release, kbd_hit;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  pmc_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .we       (ctrl_we),
    .wdata    (ctrl_wdata),
    .clr_idle (clr_idle),
    .clr_pd   (clr_pd),
    .idle_req (idle_req),
    .pd_req   (pd_req),
    .rdata    (ctrl_rd)
  );

  pmc_wake_qual #(
    .NUM_EXT     (NUM_EXT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_wake (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .ext_n       (ext_n),
    .ext_en      (ext_en),
    .kbd_irq     (kbd_irq),
    .kbd_en      (kbd_en),
    .arm_clr     (arm_clr),
    .arm_act     (arm_act),
    .ext_low_hit (ext_low_hit),
    .ext_release (ext_release),
    .kbd_hit     (kbd_hit)
  );

  pmc_seq_fsm #(
    .STAB_W  (STAB_W),
    .KBD_DLY (KBD_DLY)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .idle_req    (idle_req),
    .pd_req      (pd_req),
    .irq_pend    (irq_pend),
    .ext_low_hit (ext_low_hit),
    .ext_release (ext_release),
    .kbd_hit     (kbd_hit),
    .osc_ready   (osc_ready),
    .stab_limit  (stab_limit),
    .clr_idle    (clr_idle),
    .clr_pd      (clr_pd),
    .arm_clr     (arm_clr),
    .arm_act     (arm_act),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .strobe_hold (strobe_hold),
    .port_hold   (port_hold)
  );

  assert_pd_cpu_off_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!osc_en) |-> (!cpu_clk_en && !per_clk_en));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int KBD_DLY = 1024;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_we;
  logic [3:0] ctrl_wdata;
  logic [3:0] ctrl_rd;
  logic       irq_pend;
  logic [1:0] ext_n, ext_en;
  logic       kbd_irq, kbd_en, osc_ready;
  logic [7:0] stab_limit;
  logic       cpu_clk_en, per_clk_en, osc_en, strobe_hold, port_hold;
  logic [2:0] osc_pipe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // oscillator model: ready three edges after enable
  always @(posedge clk) osc_pipe <= {osc_pipe[1:0], osc_en};
  assign osc_ready = osc_pipe[2] & osc_en;

  pwr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rd(ctrl_rd), .irq_pend(irq_pend), .ext_n(ext_n), .ext_en(ext_en),
    .kbd_irq(kbd_irq), .kbd_en(kbd_en), .osc_ready(osc_ready),
    .stab_limit(stab_limit), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .strobe_hold(strobe_hold), .port_hold(port_hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {27'd0, cpu_clk_en, per_clk_en, osc_en, strobe_hold, port_hold};
  endfunction

  task automatic wr(input logic [3:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_osc(input string req);
    int n = 0;
    while (!osc_en && n < 20) begin @(negedge clk); n++; end
    chk(req, osc_en, 1);
  endtask

  task automatic gap_to_cpu(output int n);
    n = 0;
    while (!cpu_clk_en && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 outputs after reset", outs(), 5'b11100);
    chk("R1 register after reset", ctrl_rd, 0);
  endtask

  task automatic t_idle();
    wr(4'b0001);
    chk("R2 idle outputs", outs(), 5'b01111);
    chk("R2 idle bit read", ctrl_rd, 4'b0001);
    repeat (5) @(negedge clk);
    chk("R2 cpu stays off in idle", cpu_clk_en, 0);
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;
    chk("R3 cpu back after irq", outs(), 5'b11100);
    chk("R3 idle bit cleared", ctrl_rd, 0);
  endtask

  task automatic t_flags();
    wr(4'b1101);
    chk("R4 flags with idle", ctrl_rd, 4'b1101);
    chk("R2 idle with flags", cpu_clk_en, 0);
    irq_pend = 1'b1; @(negedge clk); irq_pend = 1'b0;
    chk("R4 flags kept after wake", ctrl_rd, 4'b1100);
    wr(4'b0100);
    chk("R4 flag write alone", ctrl_rd, 4'b0100);
    chk("R4 flag write no sleep", cpu_clk_en, 1);
    wr(4'b0000);
  endtask

  task automatic t_pd_irq_reset();
    wr(4'b0010);
    chk("R5 power-down outputs", outs(), 5'b00011);
    irq_pend = 1'b1; repeat (6) @(negedge clk);
    chk("R5 irq ignored in power-down", osc_en, 0);
    irq_pend = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    chk("R1 reset ends power-down", outs(), 5'b11100);
    rst_n = 1'b1; repeat (3) @(negedge clk);
    chk("R1 register cleared by reset", ctrl_rd, 0);
  endtask

  task automatic t_prec_kbd();
    int n;
    wr(4'b0011);
    chk("R6 combined write read", ctrl_rd, 4'b0010);
    chk("R6 combined write enters power-down", osc_en, 0);
    kbd_en = 1'b1; kbd_irq = 1'b1;
    wait_osc("R11 keyboard restarts oscillator");
    kbd_irq = 1'b0;
    gap_to_cpu(n);
    chk("R11 keyboard delay cycles", n, KBD_DLY + 3);
    chk("R11 power-down bit cleared", ctrl_rd, 0);
    kbd_en = 1'b0;
  endtask

  task automatic t_disabled_and_held();
    stab_limit = 8'd10; ext_en = 2'b10;
    wr(4'b0010);
    ext_n[0] = 1'b0; repeat (10) @(negedge clk);
    chk("R7 disabled pin no wake", osc_en, 0);
    ext_n[1] = 1'b0;
    wait_osc("R8 enabled pin restarts oscillator");
    begin
      int on = 0;
      repeat (40) begin @(negedge clk); on += cpu_clk_en; end
      chk("R8 cpu off while pin held", on, 0);
    end
    ext_n[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 cpu off before release seen", cpu_clk_en, 0);
    @(negedge clk);
    chk("R8 release completes exit", cpu_clk_en, 1);
    chk("R8 power-down bit cleared", ctrl_rd, 0);
    ext_n[0] = 1'b1; ext_en = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_early(input int lim);
    int n;
    stab_limit = 8'(lim); ext_en = 2'b01;
    wr(4'b0010);
    ext_n[0] = 1'b0;
    wait_osc("R9 pin restarts oscillator");
    ext_n[0] = 1'b1;
    gap_to_cpu(n);
    chk("R9 stabilization exit cycles", n, lim + 4);
    ext_en = 2'b00;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_both();
    stab_limit = 8'd10; ext_en = 2'b11;
    wr(4'b0010);
    ext_n[0] = 1'b0;
    wait_osc("R10 either pin restarts oscillator");
    ext_n[1] = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 cpu off while both held", cpu_clk_en, 0);
    ext_n[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 not yet exited", cpu_clk_en, 0);
    @(negedge clk);
    chk("R10 first release exits", cpu_clk_en, 1);
    ext_n[0] = 1'b1; repeat (4) @(negedge clk);
    chk("R10 stays running after other release", outs(), 5'b11100);
    ext_en = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; irq_pend = 1'b0;
    ext_n = 2'b11; ext_en = 2'b00; kbd_irq = 1'b0; kbd_en = 1'b0;
    stab_limit = 8'd10;
    @(negedge clk);
    chk("R1 outputs during reset", outs(), 5'b11100);
    do_reset();
    t_reset();
    t_idle();
    t_flags();
    t_pd_irq_reset();
    t_prec_kbd();
    t_disabled_and_held();
    t_early(10);
    t_early(3);
    t_both();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule